// File: doc/BRIEF.md
# CPU clock PLL retune sequencer

This block changes the CPU clock frequency in hardware. A requester presents a rate in MHz together with a one-cycle valid strobe. The rate is compared against a fixed table of nine legal operating points. Each point gives an input divider, a feedback multiplier and a post-divider for the CPU PLL. A rate that is not in the table is refused: the error flag rises and no output word changes.

An accepted rate starts a sequence held in an enumerated state machine. The states are IDLE, PARK, PROGRAM, ARM, POLL, SETTLE, RESUME and ABORT, and the transitions are:
- IDLE to PARK when a request matches the table.
- PARK to PROGRAM: the clock-policy word switches the CPU to the oscillator with the CPU state set to idle.
- PROGRAM to ARM: the three divider fields of the PLL base word are replaced.
- ARM to POLL: the lock-enable bit is set.
- POLL samples the lock input once per poll interval:
  - POLL to SETTLE when lock is seen.
  - POLL to POLL when lock is absent and the poll budget remains.
  - POLL to ABORT after the last allowed failed poll.
- SETTLE to RESUME once the settling delay has run out.
- RESUME to IDLE: the CPU returns to the PLL output in the run state.
- ABORT to IDLE: the CPU stays parked on the oscillator and the error flag is raised.

The block also reports the current rate. This value is recomputed at all times from the divider fields held in the PLL base word. Delays are counted in cycles: a parameter gives the number of clock cycles per microsecond.

Top module: `pll_retune_seq`

## Requirements
- R1: Each legal rate (2292, 2100, 1896, 1692, 1500, 1296, 1092, 900, 696 MHz) programs input divider 1, post-divider 0 and multiplier 191, 175, 158, 141, 125, 108, 91, 75 or 58 respectively.
- R2: A request whose rate is not exactly one of the legal rates sets `err_o`. It leaves `busy_o` low and leaves the policy and base words unchanged.
- R3: The policy word holds the CPU state in bits 31:28 (1 = idle, 2 = run) and the clock source in bits 3:0 (0 = oscillator, 8 = PLL output). Every write by the block keeps all other bits of the word.
- R4: In the PLL base word, the input divider is in bits 7:0, the multiplier in bits 17:8 and the post-divider in bits 23:20. All other bits are kept. The word changes only while the policy word shows idle on the oscillator.
- R5: Bit 18 of the misc word (lock enable) is set before the policy word is returned to run. `lock_i` is sampled only at the end of each poll interval of POLL_US microseconds.
- R6: After lock is seen, the block waits SETTLE_US microseconds and then writes run state with the PLL source. When lock is present at the first poll, `busy_o` is high for exactly 4 + poll cycles + settle cycles clock cycles.
- R7: `busy_o` rises on the edge that accepts a request and falls on the edge of the final policy write. The policy word shows idle during every busy cycle after the first. Requests that arrive while busy are ignored.
- R8: After MAX_POLLS consecutive failed polls, the block aborts. The policy word stays idle on the oscillator, `err_o` rises and `busy_o` falls, 4 + MAX_POLLS × poll cycles after acceptance.
- R9: `cur_mhz_o` equals REF_MHZ × multiplier / (input divider << post-divider), taken from the base word.
- R10: An accepted request clears `err_o`.
- R11: After reset the policy, base and misc words equal their init parameters, and `busy_o` and `err_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | One-cycle request strobe |
| req_mhz_i | input | 12 | Requested rate in MHz |
| lock_i | input | 1 | PLL lock status |
| policy_o | output | 32 | Clock-policy word (CPU state, source) |
| pll_base_o | output | 32 | PLL base word with divider fields |
| pll_misc_o | output | 32 | PLL misc word, bit 18 lock enable |
| busy_o | output | 1 | Retune in progress |
| err_o | output | 1 | Last request refused or aborted |
| cur_mhz_o | output | 12 | Rate computed from the base word |

## Verification
The properties take for granted that a request strobe lasts one cycle and that the rate stays valid while the strobe is high. The bench drives every request for exactly one cycle away from the clock edge. The properties also assume that the init parameters describe a running CPU on the PLL output, which the bench's default parameters do. The lock input is produced by a model of the PLL: lock rises a chosen number of cycles after the lock enable is set and the divider fields settle, or never rises. This keeps the lock input meaningful only while the block is polling.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_PARK, S_PROGRAM, S_ARM, S_POLL, S_SETTLE, S_RESUME, S_ABORT
    } seq_state_t;

    localparam int NUM_POINTS = 9;
    localparam int RATE_W     = 12;
    localparam int MUL_W      = 10;
    localparam int DIVM_W     = 8;
    localparam int DIVP_W     = 4;

    // field positions
    localparam int CPU_ST_LSB = 28;
    localparam int SRC_LSB    = 0;
    localparam int DIVM_LSB   = 0;
    localparam int MUL_LSB    = 8;
    localparam int DIVP_LSB   = 20;
    localparam int LOCK_EN_BIT = 18;

    localparam logic [3:0] CPU_IDLE = 4'd1;
    localparam logic [3:0] CPU_RUN  = 4'd2;
    localparam logic [3:0] SRC_OSC  = 4'd0;
    localparam logic [3:0] SRC_PLL  = 4'd8;

    function automatic logic [RATE_W-1:0] point_rate(input int i);
        case (i)
            0: point_rate = 12'd2292;
            1: point_rate = 12'd2100;
            2: point_rate = 12'd1896;
            3: point_rate = 12'd1692;
            4: point_rate = 12'd1500;
            5: point_rate = 12'd1296;
            6: point_rate = 12'd1092;
            7: point_rate = 12'd900;
            default: point_rate = 12'd696;
        endcase
    endfunction

    function automatic logic [MUL_W-1:0] point_mul(input int i);
        case (i)
            0: point_mul = 10'd191;
            1: point_mul = 10'd175;
            2: point_mul = 10'd158;
            3: point_mul = 10'd141;
            4: point_mul = 10'd125;
            5: point_mul = 10'd108;
            6: point_mul = 10'd91;
            7: point_mul = 10'd75;
            default: point_mul = 10'd58;
        endcase
    endfunction

    function automatic logic [DIVM_W-1:0] point_divm(input int i);
        point_divm = (i >= 0) ? 8'd1 : 8'd1;
    endfunction

    function automatic logic [DIVP_W-1:0] point_divp(input int i);
        point_divp = (i >= 0) ? 4'd0 : 4'd0;
    endfunction

    function automatic logic legal_rate(input logic [RATE_W-1:0] r);
        legal_rate = 1'b0;
        for (int i = 0; i < NUM_POINTS; i++)
            if (point_rate(i) == r) legal_rate = 1'b1;
    endfunction

endpackage

// File: rtl/pll_rate_table.sv
module pll_rate_table
    import pll_retune_pkg::*;
(
    input  logic [RATE_W-1:0] rate_i,
    output logic              hit_o,
    output logic [DIVM_W-1:0] divm_o,
    output logic [MUL_W-1:0]  mul_o,
    output logic [DIVP_W-1:0] divp_o
);
    logic [NUM_POINTS-1:0] match;

    for (genvar g = 0; g < NUM_POINTS; g++) begin : g_point
        assign match[g] = (rate_i == point_rate(g));
    end

    always_comb begin
        divm_o = '0;
        mul_o  = '0;
        divp_o = '0;
        for (int i = 0; i < NUM_POINTS; i++) begin
            if (match[i]) begin
                divm_o = divm_o | point_divm(i);
                mul_o  = mul_o  | point_mul(i);
                divp_o = divp_o | point_divp(i);
            end
        end
    end

    assign hit_o = |match;
endmodule

// File: rtl/pll_retune_timer.sv
module pll_retune_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] value_i,
    output logic         done_o
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt <= '0;
        else if (load_i)        cnt <= value_i;
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign done_o = (cnt == '0);
endmodule

// File: rtl/pll_rate_readback.sv
module pll_rate_readback
    import pll_retune_pkg::*;
#(
    parameter int REF_MHZ = 12
) (
    input  logic [31:0]       base_i,
    output logic [RATE_W-1:0] mhz_o
);
    localparam int PROD_W = 32;

    logic [DIVM_W-1:0] divm;
    logic [MUL_W-1:0]  mul;
    logic [DIVP_W-1:0] divp;
    logic [PROD_W-1:0] num, den, quo;

    assign divm = base_i[DIVM_LSB +: DIVM_W];
    assign mul  = base_i[MUL_LSB  +: MUL_W];
    assign divp = base_i[DIVP_LSB +: DIVP_W];

    always_comb begin
        num = PROD_W'(REF_MHZ) * PROD_W'(mul);
        den = PROD_W'(divm) << divp;
        quo = (den == '0) ? '0 : num / den;
    end

    assign mhz_o = quo[RATE_W-1:0];
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
    import pll_retune_pkg::*;
#(
    parameter int          REF_MHZ     = 12,
    parameter int          TICK_CYC    = 100,
    parameter int          POLL_US     = 2,
    parameter int          SETTLE_US   = 100,
    parameter int          MAX_POLLS   = 64,
    parameter logic [31:0] POLICY_INIT = 32'h2055_5558,
    parameter logic [31:0] BASE_INIT   = 32'h4800_BF01,
    parameter logic [31:0] MISC_INIT   = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid_i,
    input  logic [11:0] req_mhz_i,
    input  logic        lock_i,
    output logic [31:0] policy_o,
    output logic [31:0] pll_base_o,
    output logic [31:0] pll_misc_o,
    output logic        busy_o,
    output logic        err_o,
    output logic [11:0] cur_mhz_o
);
    localparam int POLL_CYC   = POLL_US * TICK_CYC;
    localparam int SETTLE_CYC = SETTLE_US * TICK_CYC;
    localparam int MAX_CYC    = (POLL_CYC > SETTLE_CYC) ? POLL_CYC : SETTLE_CYC;
    localparam int TMR_W      = $clog2(MAX_CYC + 1);
    localparam int PC_W       = $clog2(MAX_POLLS + 1);

    seq_state_t state, nxt;

    logic              hit;
    logic [DIVM_W-1:0] t_divm, l_divm;
    logic [MUL_W-1:0]  t_mul,  l_mul;
    logic [DIVP_W-1:0] t_divp, l_divp;
    logic [PC_W-1:0]   poll_cnt;
    logic              tmr_load, tmr_done;
    logic [TMR_W-1:0]  tmr_val;
    logic              last_poll;

    pll_rate_table u_table (
        .rate_i (req_mhz_i),
        .hit_o  (hit),
        .divm_o (t_divm),
        .mul_o  (t_mul),
        .divp_o (t_divp)
    );

    pll_retune_timer #(.W(TMR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (tmr_load),
        .value_i (tmr_val),
        .done_o  (tmr_done)
    );

    pll_rate_readback #(.REF_MHZ(REF_MHZ)) u_readback (
        .base_i (pll_base_o),
        .mhz_o  (cur_mhz_o)
    );

    assign last_poll = (poll_cnt == PC_W'(MAX_POLLS - 1));

    // timer reload control
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (state == S_ARM) begin
            tmr_load = 1'b1;
            tmr_val  = TMR_W'(POLL_CYC - 1);
        end else if (state == S_POLL && tmr_done) begin
            if (lock_i) begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(SETTLE_CYC - 1);
            end else if (!last_poll) begin
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(POLL_CYC - 1);
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:    if (req_valid_i && hit) nxt = S_PARK;
            S_PARK:    nxt = S_PROGRAM;
            S_PROGRAM: nxt = S_ARM;
            S_ARM:     nxt = S_POLL;
            S_POLL:    if (tmr_done) begin
                           if (lock_i)         nxt = S_SETTLE;
                           else if (last_poll) nxt = S_ABORT;
                       end
            S_SETTLE:  if (tmr_done) nxt = S_RESUME;
            S_RESUME:  nxt = S_IDLE;
            S_ABORT:   nxt = S_IDLE;
            default:   nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            policy_o   <= POLICY_INIT;
            pll_base_o <= BASE_INIT;
            pll_misc_o <= MISC_INIT;
            busy_o     <= 1'b0;
            err_o      <= 1'b0;
            poll_cnt   <= '0;
            l_divm     <= '0;
            l_mul      <= '0;
            l_divp     <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid_i) begin
                    if (hit) begin
                        busy_o <= 1'b1;
                        err_o  <= 1'b0;
                        l_divm <= t_divm;
                        l_mul  <= t_mul;
                        l_divp <= t_divp;
                    end else begin
                        err_o  <= 1'b1;
                    end
                end
                S_PARK: begin
                    policy_o[CPU_ST_LSB +: 4] <= CPU_IDLE;
                    policy_o[SRC_LSB +: 4]    <= SRC_OSC;
                end
                S_PROGRAM: begin
                    pll_base_o[DIVM_LSB +: DIVM_W] <= l_divm;
                    pll_base_o[MUL_LSB  +: MUL_W]  <= l_mul;
                    pll_base_o[DIVP_LSB +: DIVP_W] <= l_divp;
                end
                S_ARM: begin
                    pll_misc_o[LOCK_EN_BIT] <= 1'b1;
                    poll_cnt <= '0;
                end
                S_POLL: if (tmr_done && !lock_i && !last_poll)
                    poll_cnt <= poll_cnt + 1'b1;
                S_SETTLE: ;
                S_RESUME: begin
                    policy_o[CPU_ST_LSB +: 4] <= CPU_RUN;
                    policy_o[SRC_LSB +: 4]    <= SRC_PLL;
                    busy_o <= 1'b0;
                end
                S_ABORT: begin
                    policy_o[CPU_ST_LSB +: 4] <= CPU_IDLE;
                    policy_o[SRC_LSB +: 4]    <= SRC_OSC;
                    busy_o <= 1'b0;
                    err_o  <= 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pll_retune_checker.sv
module pll_retune_checker
    import pll_retune_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid_i,
    input logic [11:0] req_mhz_i,
    input logic [31:0] policy_o,
    input logic [31:0] pll_base_o,
    input logic [31:0] pll_misc_o,
    input logic        busy_o,
    input logic        err_o
);
    // R2
    a_r2_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && req_valid_i && !legal_rate(req_mhz_i)) |=>
            ($stable(policy_o) && $stable(pll_base_o) && !busy_o && err_o));

    // R3
    a_r3_run_on_pll: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_o[31:28] == CPU_RUN) |-> (policy_o[3:0] == SRC_PLL));

    // R4
    a_r4_program_while_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_base_o != $past(pll_base_o)) |->
            (policy_o[31:28] == CPU_IDLE && policy_o[3:0] == SRC_OSC));

    // R5
    a_r5_lock_enabled_before_run: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_o[31:28] == CPU_RUN && $past(policy_o[31:28]) != CPU_RUN) |->
            pll_misc_o[LOCK_EN_BIT]);

    // R7
    a_r7_parked_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (policy_o[31:28] == CPU_IDLE));

    // R8
    a_r8_abort_stays_on_osc: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && err_o) |->
            (policy_o[31:28] == CPU_IDLE && policy_o[3:0] == SRC_OSC));
endmodule

bind pll_retune_seq pll_retune_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid_i (req_valid_i),
    .req_mhz_i   (req_mhz_i),
    .policy_o    (policy_o),
    .pll_base_o  (pll_base_o),
    .pll_misc_o  (pll_misc_o),
    .busy_o      (busy_o),
    .err_o       (err_o)
);

// File: tb/pll_retune_seq_bench.sv
module pll_retune_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK = 1, PUS = 2, SUS = 10, MAXP = 6;
    localparam int PC = PUS * TICK, SC = SUS * TICK;
    localparam logic [31:0] P_INIT = 32'h2055_5558;
    localparam logic [31:0] B_INIT = 32'h4800_BF01;
    localparam logic [31:0] FIELD_MASK = 32'h00F3_FFFF;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0;
    logic [11:0] req_mhz = '0;
    logic lock = 0;
    logic [31:0] policy, base, misc;
    logic busy, err;
    logic [11:0] cur;

    int errs = 0, checks = 0;
    int lock_delay = 0;
    bit never_lock = 0;
    int lock_age = 0;
    logic [31:0] base_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_retune_seq #(.TICK_CYC(TICK), .POLL_US(PUS), .SETTLE_US(SUS),
                     .MAX_POLLS(MAXP), .POLICY_INIT(P_INIT), .BASE_INIT(B_INIT))
    u_pll_retune_seq (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_mhz_i(req_mhz),
        .lock_i(lock), .policy_o(policy), .pll_base_o(base), .pll_misc_o(misc),
        .busy_o(busy), .err_o(err), .cur_mhz_o(cur));

    // PLL model
    always @(negedge clk) begin
        if (!rst_n || !misc[18] || base != base_q) lock_age = 0;
        else lock_age = lock_age + 1;
        base_q = base;
        lock = misc[18] && !never_lock && (lock_age >= lock_delay);
    end

    function automatic int exp_mul(input int r);
        case (r)
            2292: return 191; 2100: return 175; 1896: return 158;
            1692: return 141; 1500: return 125; 1296: return 108;
            1092: return 91;  900:  return 75;  696:  return 58;
            default: return -1;
        endcase
    endfunction

    function automatic int pick_rate(input int i);
        int t[9] = '{2292, 2100, 1896, 1692, 1500, 1296, 1092, 900, 696};
        return t[i];
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic send(input int r);
        @(negedge clk);
        req_valid = 1; req_mhz = 12'(r);
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        while (busy && n < 5000) begin n++; @(negedge clk); end
    endtask

    task automatic check_legal(input int r, input int n, input bit exact);
        int m = exp_mul(r);
        check(base[7:0] == 8'd1, "R1 divm", base[7:0], 1);
        check(base[17:8] == 10'(m), "R1 mul", base[17:8], m);
        check(base[23:20] == 4'd0, "R1 divp", base[23:20], 0);
        check((base & ~FIELD_MASK) == (B_INIT & ~FIELD_MASK), "R4 other bits", base, B_INIT);
        check(policy == ((P_INIT & 32'h0FFF_FFF0) | 32'h2000_0008), "R3 R6 run policy", policy,
              (P_INIT & 32'h0FFF_FFF0) | 32'h2000_0008);
        check(cur == 12'(r), "R9 readback", cur, r);
        check(err == 1'b0, "R10 err cleared", err, 0);
        check(misc[18] == 1'b1, "R5 lock enable", misc[18], 1);
        if (exact) check(n == 4 + PC + SC, "R6 busy length", n, 4 + PC + SC);
        else check(n >= 4 + PC + SC && n <= 4 + MAXP*PC + SC, "R6 busy bound", n, 4 + PC + SC);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin : main
        int n;
        logic [31:0] pb, bb;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(policy == P_INIT, "R11 policy", policy, P_INIT);
        check(base == B_INIT, "R11 base", base, B_INIT);
        check(misc == 32'h0, "R11 misc", misc, 0);
        check(busy == 0 && err == 0, "R11 flags", {busy, err}, 0);
        rst_n = 1;
        @(negedge clk);

        // directed: lock at first poll, exact timing
        lock_delay = 0;
        send(1500); wait_done(n); check_legal(1500, n, 1);

        // R2 illegal request
        pb = policy; bb = base;
        send(1501); @(negedge clk);
        check(err == 1, "R2 err", err, 1);
        check(busy == 0, "R2 busy", busy, 0);
        check(policy == pb && base == bb, "R2 unchanged", base, bb);

        // R7 request while busy ignored
        send(900);
        repeat (3) @(negedge clk);
        req_valid = 1; req_mhz = 12'd2292; @(negedge clk); req_valid = 0;
        wait_done(n);
        check(base[17:8] == 10'd75, "R7 busy ignores request", base[17:8], 75);
        check(policy[31:28] == 4'd2, "R7 final run", policy[31:28], 2);

        // R8 abort
        never_lock = 1;
        send(2100); wait_done(n);
        check(n == 4 + MAXP*PC, "R8 abort length", n, 4 + MAXP*PC);
        check(err == 1, "R8 err", err, 1);
        check(policy[31:28] == 4'd1 && policy[3:0] == 4'd0, "R8 parked", policy, 32'h1);
        never_lock = 0;

        // every table point
        for (int i = 0; i < 9; i++) begin
            lock_delay = 0;
            send(pick_rate(i)); wait_done(n); check_legal(pick_rate(i), n, 1);
        end

        // random mix
        for (int k = 0; k < 40; k++) begin
            int r;
            lock_delay = $urandom_range(0, 8);
            if ($urandom_range(0, 9) < 7) r = pick_rate($urandom_range(0, 8));
            else begin
                r = $urandom_range(0, 4095);
                if (exp_mul(r) >= 0) r = r ^ 1;
            end
            if (exp_mul(r) >= 0) begin
                send(r); wait_done(n); check_legal(r, n, 0);
            end else begin
                pb = policy; bb = base;
                send(r); @(negedge clk);
                check(err == 1 && busy == 0, "R2 random reject", {busy, err}, 1);
                check(policy == pb && base == bb, "R2 random unchanged", base, bb);
            end
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule